// File: doc/BRIEF.md
# MFM Preamble High-Frequency Detector

This block sits in front of the phase-locked loop of a disk read channel. While the read gate is inactive, the loop keeps tracking a local reference clock that runs at twice the data-clock rate. Once the read gate goes true, the block watches the raw MFM pulse stream. It waits for a steady field of all ones or all zeros. In such a field the pulses are spaced exactly one data-clock period apart. Only then does it switch the loop input over to live read data.

The analog retriggerable one-shot is replaced by a down-counter clocked by an oversampling system clock. Every pulse reloads the counter with a window length of about 1.25 data-clock periods. A pulse that arrives while the window is still open counts as a retrigger. If the window runs out first, the run count is cleared. The window lengths for the two supported data rates are parameters in system-clock cycles, and an input picks between them.

When the run count reaches 16 retriggers, the select output locks onto data. It stays there until the read gate falls. Falling read gate returns the loop to the reference clock and clears all detection state.

Top module: `mfm_hf_detect`

## Requirements
- R1: During reset and in every cycle after a cycle in which `rd_gate` is low, `sel_data` is 0, which selects the reference clock.
- R2: Each rising edge of `pulse_in` is counted exactly once, whatever its width. After the pulse that completes a run, `sel_data` goes to 1 on the third rising clock edge that samples `pulse_in` high.
- R3: A pulse whose rising edge follows the previous one by at most W clock cycles is a retrigger.
- R4: If W+1 or more cycles pass without a pulse, the run count is cleared. The next pulse only opens a new window and is not a retrigger.
- R5: `sel_data` becomes 1 after the 16th consecutive retrigger, which is 17 pulses with no expiry between them. 16 such pulses are not enough.
- R6: Once `sel_data` is 1, it stays 1 while `rd_gate` stays high, whatever the later pulse spacing, including no pulses at all.
- R7: Pulses that arrive while `rd_gate` is low are ignored. Run state is cleared, so a new run after `rd_gate` rises needs a full 17 pulses.
- R8: Detection begins in the first cycle of `rd_gate` high. A pulse in that cycle opens the first window.
- R9: W equals parameter WIN_FAST when `rate_slow` is 0 and WIN_SLOW when `rate_slow` is 1. The defaults are 31 and 36 cycles, which is 250 ns and 287 ns at 125 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_gate | input | 1 | Read gate, synchronous to clk; high enables detection |
| rate_slow | input | 1 | Rate select: 0 picks WIN_FAST, 1 picks WIN_SLOW |
| pulse_in | input | 1 | Raw MFM pulse stream, asynchronous |
| sel_data | output | 1 | Loop input select: 0 reference clock, 1 read data |

## Verification
The hardest situation to reach from the ports is the exact window edge. The first case is a pulse landing in the last open cycle of the window, which must retrigger. The second is a pulse landing one cycle later, which must not retrigger. Both have to happen with the run count one short of the lock threshold. The stimulus reaches these cases by sweeping the pulse spacing through every value from 2 to W+3 cycles at both rates. Each sweep point sends a run of exactly 17 equally spaced pulses, so the outcome flips precisely between spacing W and W+1.

// File: rtl/mfm_hf_pkg.sv
package mfm_hf_pkg;
  typedef enum logic {
    SRC_REF  = 1'b0,
    SRC_DATA = 1'b1
  } loop_src_e;
endpackage

// File: rtl/mfm_pulse_sync.sv
module mfm_pulse_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic meta_q, sync_q, prev_q;
  logic meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = async_i;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/mfm_retrig_window.sv
module mfm_retrig_window #(
  parameter int TMR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_i,
  input  logic             edge_i,
  input  logic [TMR_W-1:0] win_len_i,
  output logic             hit_o,
  output logic             expire_o,
  output logic [TMR_W-1:0] tmr_o
);
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;
  logic             open_w;

  assign open_w   = (tmr_q != '0);
  assign hit_o    = gate_i & edge_i & open_w;
  assign expire_o = gate_i & ~edge_i & (tmr_q == TMR_W'(1));

  always_comb begin
    tmr_en = 1'b0;
    tmr_d  = tmr_q;
    if (!gate_i) begin
      tmr_en = open_w;
      tmr_d  = '0;
    end else if (edge_i) begin
      tmr_en = 1'b1;
      tmr_d  = win_len_i;
    end else if (open_w) begin
      tmr_en = 1'b1;
      tmr_d  = tmr_q - TMR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  assign tmr_o = tmr_q;
endmodule

// File: rtl/mfm_run_counter.sv
module mfm_run_counter #(
  parameter int RUN_TARGET = 16,
  parameter int RUN_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_i,
  input  logic             hit_i,
  input  logic             expire_i,
  output logic [RUN_W-1:0] run_o,
  output logic             lock_o
);
  localparam logic [RUN_W-1:0] LAST = RUN_W'(RUN_TARGET - 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic             lock_q, lock_d;
  logic             upd_en;

  always_comb begin
    upd_en = 1'b0;
    run_d  = run_q;
    lock_d = lock_q;
    if (!gate_i) begin
      upd_en = 1'b1;
      run_d  = '0;
      lock_d = 1'b0;
    end else if (!lock_q) begin
      if (hit_i) begin
        upd_en = 1'b1;
        run_d  = run_q + RUN_W'(1);
        lock_d = (run_q == LAST);
      end else if (expire_i) begin
        upd_en = 1'b1;
        run_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (upd_en) begin
      run_q  <= run_d;
      lock_q <= lock_d;
    end
  end

  assign run_o  = run_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/mfm_hf_detect.sv
module mfm_hf_detect #(
  parameter int WIN_FAST   = 31,
  parameter int WIN_SLOW   = 36,
  parameter int RUN_TARGET = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_gate,
  input  logic rate_slow,
  input  logic pulse_in,
  output logic sel_data
);
  import mfm_hf_pkg::*;

  localparam int WIN_MAX = (WIN_FAST > WIN_SLOW) ? WIN_FAST : WIN_SLOW;
  localparam int TMR_W   = $clog2(WIN_MAX + 1);
  localparam int RUN_W   = $clog2(RUN_TARGET + 1);

  logic             rst_meta_q, rst_sync_q;
  logic             pulse_edge;
  logic [TMR_W-1:0] win_len;
  logic [TMR_W-1:0] tmr;
  logic             hit, expire;
  logic [RUN_W-1:0] run_cnt;
  logic             lock;
  loop_src_e        src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign win_len = rate_slow ? TMR_W'(WIN_SLOW) : TMR_W'(WIN_FAST);

  mfm_pulse_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .async_i (pulse_in),
    .rise_o  (pulse_edge)
  );

  mfm_retrig_window #(.TMR_W(TMR_W)) u_win (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .gate_i    (rd_gate),
    .edge_i    (pulse_edge),
    .win_len_i (win_len),
    .hit_o     (hit),
    .expire_o  (expire),
    .tmr_o     (tmr)
  );

  mfm_run_counter #(.RUN_TARGET(RUN_TARGET), .RUN_W(RUN_W)) u_run (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .gate_i   (rd_gate),
    .hit_i    (hit),
    .expire_i (expire),
    .run_o    (run_cnt),
    .lock_o   (lock)
  );

  assign src      = lock ? SRC_DATA : SRC_REF;
  assign sel_data = (src == SRC_DATA);
endmodule

// File: rtl/mfm_hf_detect_chk.sv
module mfm_hf_detect_chk #(
  parameter int TMR_W      = 6,
  parameter int RUN_W      = 5,
  parameter int RUN_TARGET = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_gate,
  input logic             sel_data,
  input logic             pulse_edge,
  input logic [TMR_W-1:0] tmr,
  input logic [TMR_W-1:0] win_len,
  input logic [RUN_W-1:0] run_cnt
);
  a_r1_ref_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_gate |=> !sel_data);

  a_r6_hold_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_data && rd_gate) |=> sel_data);

  a_r5_lock_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_data) |-> $past(pulse_edge));

  a_r3_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tmr <= win_len);

  a_r5_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_W'(RUN_TARGET));

  a_r7_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_gate |=> (run_cnt == '0 && tmr == '0));
endmodule

bind mfm_hf_detect mfm_hf_detect_chk #(
  .TMR_W(TMR_W), .RUN_W(RUN_W), .RUN_TARGET(RUN_TARGET)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_q),
  .rd_gate    (rd_gate),
  .sel_data   (sel_data),
  .pulse_edge (pulse_edge),
  .tmr        (tmr),
  .win_len    (win_len),
  .run_cnt    (run_cnt)
);

// File: tb/mfm_hf_detect_tb_top.sv
`timescale 1ns/1ps
module mfm_hf_detect_tb_top;
  localparam int WF = 31;
  localparam int WS = 36;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_gate = 1'b0;
  logic rate_slow = 1'b0;
  logic pulse_in = 1'b0;
  logic sel_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mfm_hf_detect #(.WIN_FAST(WF), .WIN_SLOW(WS), .RUN_TARGET(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_gate(rd_gate), .rate_slow(rate_slow),
    .pulse_in(pulse_in), .sel_data(sel_data)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: sel_data=%0b expected %0b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input int n, input int sp);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pulse_in = 1'b1;
      @(negedge clk); pulse_in = 1'b0;
      idle(sp - 2);
    end
  endtask

  task automatic restart();
    @(negedge clk); rd_gate = 1'b0;
    idle(3);
    rd_gate = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(2);
    check("R1 reset", sel_data, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    check("R1 idle after reset", sel_data, 1'b0);

    // R7: pulses while gate low are ignored, then 16 pulses after gate rise
    send(20, 10);
    check("R7 gate low ignores pulses", sel_data, 1'b0);
    @(negedge clk); rd_gate = 1'b1;
    send(16, 10);
    idle(5);
    check("R7 no carry-over from gated-off pulses", sel_data, 1'b0);

    // R2/R8 exact latency: pulse in first gated cycle, 17 pulses
    restart();
    pulse_in = 1'b1;
    @(negedge clk); pulse_in = 1'b0;
    idle(8);
    send(15, 10);
    @(negedge clk); pulse_in = 1'b1;
    @(negedge clk); pulse_in = 1'b0;
    check("R2 still low after one edge", sel_data, 1'b0);
    @(negedge clk);
    check("R2 still low after two edges", sel_data, 1'b0);
    @(negedge clk);
    check("R2 R8 high on third edge", sel_data, 1'b1);

    // R6: hold with slow pulses and silence
    send(5, 80);
    idle(200);
    check("R6 holds while gate high", sel_data, 1'b1);
    @(negedge clk); rd_gate = 1'b0;
    @(negedge clk);
    check("R1 gate fall returns to reference", sel_data, 1'b0);

    // R4: break in the run clears count
    restart();
    send(10, 20);
    idle(WF + 5);
    send(16, 20);
    idle(3);
    check("R4 gap clears run, 16 after gap", sel_data, 1'b0);
    send(1, 20);
    idle(3);
    check("R4 17th pulse after gap locks", sel_data, 1'b1);

    // R5: 16 pulses only
    restart();
    send(16, WF);
    idle(3);
    check("R5 16 pulses not enough", sel_data, 1'b0);

    // R3 R9: spacing sweep at both rates
    for (int r = 0; r < 2; r++) begin
      int w;
      w = (r == 0) ? WF : WS;
      rate_slow = r[0];
      for (int sp = 2; sp <= w + 3; sp++) begin
        restart();
        send(17, sp);
        idle(3);
        if (r == 0) check("R3 R9 fast sweep", sel_data, (sp <= w));
        else        check("R3 R9 slow sweep", sel_data, (sp <= w));
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule